// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit watches a processor core for debug events. It has four address-compare channels, a control register and a status register. In every cycle it compares the instruction pointer that the fetch stage presents against each channel set up for instruction breakpoints. It also compares the data access that a snoop port reports (address, size and direction) against each channel set up to watch data.

The result of an evaluation is a hit vector with one bit per channel. A bit is set for every channel that matches, whether or not that channel is enabled. The vector replaces the low bits of the status register only when an enabled channel has matched, or when the core asks for a forced status update. An enabled match also produces a one-cycle debug-exception pulse for the core's exception logic.

Software reaches the three register types through a simple write/read port that uses a 3-bit register select. The PC input and the snoop input are valid-qualified observation streams. They have no ready signal: the unit never applies back-pressure and evaluates every beat in the cycle it arrives, so a producer may hold valid high on every cycle.

Top module: `dbm_unit`

## Requirements
- R1: After reset, the four address registers read 0, the status register reads 0xFFFF0FF0, the control register reads 0x00000400, and `dbg_exc` is low.
- R2: A channel whose 2-bit kind field is 00 matches in a cycle where `pc_valid` is high and `pc` equals the channel address.
- R3: Kind 01 matches only data writes (`acc_valid` and `acc_write` both high) whose byte range overlaps the channel range. Reads never match it.
- R4: Kind 11 matches any data access, read or write, whose byte range overlaps the channel range.
- R5: Kind 10 never matches, whatever the PC or the access.
- R6: Size codes for both the channel and the access are 00=1 byte, 01=2, 10=8 and 11=4. The access [a, a+sa) and the channel [b, b+sb) overlap when a < b+sb and b < a+sa, computed without address wrap.
- R7: For channel n, the enable is control bit 2n OR control bit 2n+1. The kind field is control bits [17+4n:16+4n] and the size field is control bits [19+4n:18+4n].
- R8: On a commit, status bits [3:0] become the hit vector of that cycle, which includes the bits of disabled channels. The upper status bits are kept.
- R9: If no enabled channel matches and `force_upd` is low, the status register is left unchanged, even when a disabled channel matches.
- R10: When `force_upd` is high, the status register commits the current hit vector. With no match at all, this clears bits [3:0].
- R11: `dbg_exc` is high for exactly the cycle after an evaluation in which an enabled channel matched, and low otherwise.
- R12: The register selects are 0-3 for the addresses, 4 for status and 5 for control. Status writes are ORed with 0xFFFF0FF0 and control writes with 0x00000400. Selects 6 and 7 read 0 and ignore writes. If a status write and a commit fall in the same cycle, the commit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| pc_valid | input | 1 | Instruction pointer beat is valid |
| pc | input | ADDR_W | Current instruction pointer |
| acc_valid | input | 1 | Data access beat is valid |
| acc_addr | input | ADDR_W | First byte address of the access |
| acc_len | input | 2 | Access size code |
| acc_write | input | 1 | 1 = write, 0 = read |
| force_upd | input | 1 | Commit the hit vector to status unconditionally |
| dbg_exc | output | 1 | Debug-exception pulse |

## Verification
Two events can fall in the same cycle and are provoked on purpose. In the first, a software write to the status register coincides with an enabled hit. The bench reads status back in the next cycle and expects the committed hit vector, not the written value. In the second, an instruction-fetch match and a data-access match occur together on different channels. The expected result is that both hit bits are set in one commit and that exactly one exception pulse follows. Random runs also place register writes next to matching traffic, and a bench model predicts each status word that results.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

  localparam int unsigned REG_W = 32;
  localparam int unsigned SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_STAT = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd5;

  localparam logic [REG_W-1:0] STAT_ONES = 32'hFFFF_0FF0;
  localparam logic [REG_W-1:0] CTRL_ONES = 32'h0000_0400;

  localparam int unsigned KIND_LSB = 16;
  localparam int unsigned SIZE_LSB = 18;
  localparam int unsigned FIELD_STRIDE = 4;

  typedef enum logic [1:0] {
    KIND_FETCH  = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_PORTIO = 2'b10,
    KIND_ANY    = 2'b11
  } bp_kind_e;

  function automatic logic [3:0] span_bytes(input logic [1:0] code);
    case (code)
      2'b00:   span_bytes = 4'd1;
      2'b01:   span_bytes = 4'd2;
      2'b10:   span_bytes = 4'd8;
      default: span_bytes = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/dbm_channel.sv
module dbm_channel
  import dbm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  bp_kind_e          kind,
  input  logic [1:0]        size_code,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_len,
  input  logic              acc_write,
  output logic              hit
);

  localparam int unsigned EXT_W = ADDR_W + 4;

  logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;
  logic             overlap;

  always_comb begin
    a_lo    = {4'b0, acc_addr};
    b_lo    = {4'b0, bp_addr};
    a_hi    = a_lo + {{(EXT_W-4){1'b0}}, span_bytes(acc_len)};
    b_hi    = b_lo + {{(EXT_W-4){1'b0}}, span_bytes(size_code)};
    overlap = (a_lo < b_hi) && (b_lo < a_hi);
  end

  always_comb begin
    case (kind)
      KIND_FETCH: hit = pc_valid && (pc == bp_addr);
      KIND_STORE: hit = acc_valid && acc_write && overlap;
      KIND_ANY:   hit = acc_valid && overlap;
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbm_commit.sv
module dbm_commit #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hits,
  input  logic [NUM_CH-1:0] enables,
  input  logic              force_upd,
  output logic              commit,
  output logic              dbg_exc
);

  logic armed_hit;

  always_comb begin
    armed_hit = |(hits & enables);
    commit    = armed_hit || force_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_exc <= 1'b0;
    else        dbg_exc <= armed_hit;
  end

endmodule

// File: rtl/dbm_regs.sv
module dbm_regs
  import dbm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              sel,
  input  logic [REG_W-1:0]              wdata,
  input  logic                          commit,
  input  logic [NUM_CH-1:0]             hits,
  output logic [NUM_CH-1:0][ADDR_W-1:0] bp_addr,
  output logic [REG_W-1:0]              ctrl_q,
  output logic [REG_W-1:0]              stat_q,
  output logic [REG_W-1:0]              rdata
);

  logic [ADDR_W-1:0] addr_r [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_CH; n++) addr_r[n] <= '0;
    end else if (wr_en) begin
      for (int n = 0; n < NUM_CH; n++)
        if (sel == SEL_W'(n)) addr_r[n] <= wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ctrl_q <= CTRL_ONES;
    else if (wr_en && sel == SEL_CTRL) ctrl_q <= wdata | CTRL_ONES;
  end

  // A commit outranks a software write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        stat_q <= STAT_ONES;
    else if (commit)                   stat_q <= {stat_q[REG_W-1:NUM_CH], hits};
    else if (wr_en && sel == SEL_STAT) stat_q <= wdata | STAT_ONES;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_out
    assign bp_addr[n] = addr_r[n];
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < NUM_CH; n++)
      if (sel == SEL_W'(n)) rdata = REG_W'(addr_r[n]);
    if (sel == SEL_STAT) rdata = stat_q;
    if (sel == SEL_CTRL) rdata = ctrl_q;
  end

endmodule

// File: rtl/dbm_unit.sv
module dbm_unit
  import dbm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_len,
  input  logic              acc_write,
  input  logic              force_upd,
  output logic              dbg_exc
);

  logic [NUM_CH-1:0][ADDR_W-1:0] bp_addr;
  logic [REG_W-1:0]              ctrl_q;
  logic [REG_W-1:0]              stat_q;
  logic [NUM_CH-1:0]             hit_vec;
  logic [NUM_CH-1:0]             chan_en;
  logic                          commit;

  dbm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .sel    (reg_sel),
    .wdata  (reg_wdata),
    .commit (commit),
    .hits   (hit_vec),
    .bp_addr(bp_addr),
    .ctrl_q (ctrl_q),
    .stat_q (stat_q),
    .rdata  (reg_rdata)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    bp_kind_e   kind;
    logic [1:0] size_code;

    assign chan_en[n] = ctrl_q[2*n] | ctrl_q[2*n+1];
    assign kind       = bp_kind_e'(ctrl_q[KIND_LSB + FIELD_STRIDE*n +: 2]);
    assign size_code  = ctrl_q[SIZE_LSB + FIELD_STRIDE*n +: 2];

    dbm_channel #(.ADDR_W(ADDR_W)) u_chan (
      .kind     (kind),
      .size_code(size_code),
      .bp_addr  (bp_addr[n]),
      .pc_valid (pc_valid),
      .pc       (pc),
      .acc_valid(acc_valid),
      .acc_addr (acc_addr),
      .acc_len  (acc_len),
      .acc_write(acc_write),
      .hit      (hit_vec[n])
    );
  end

  dbm_commit #(.NUM_CH(NUM_CH)) u_commit (
    .clk      (clk),
    .rst_n    (rst_n),
    .hits     (hit_vec),
    .enables  (chan_en),
    .force_upd(force_upd),
    .commit   (commit),
    .dbg_exc  (dbg_exc)
  );

endmodule

// File: rtl/dbm_unit_chk.sv
module dbm_unit_chk
  import dbm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pc_valid,
  input logic              acc_valid,
  input logic              force_upd,
  input logic              reg_wr_en,
  input logic              dbg_exc,
  input logic [REG_W-1:0]  stat_q,
  input logic [REG_W-1:0]  ctrl_q,
  input logic [NUM_CH-1:0] hit_vec
);

  logic [NUM_CH-1:0] io_mask;
  always_comb
    for (int n = 0; n < NUM_CH; n++)
      io_mask[n] = (ctrl_q[KIND_LSB + FIELD_STRIDE*n +: 2] == 2'b10);

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_valid || acc_valid || force_upd || reg_wr_en) |=> $stable(stat_q));

  assert_exc_needs_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc |-> $past(pc_valid || acc_valid));

  assert_exc_marks_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc |-> (stat_q[NUM_CH-1:0] != '0));

  assert_stat_ones_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & STAT_ONES) == STAT_ONES);

  assert_ctrl_ones_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & CTRL_ONES) == CTRL_ONES);

  assert_io_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & io_mask) == '0);

  assert_no_beat_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_valid || acc_valid) |-> (hit_vec == '0));

endmodule

bind dbm_unit dbm_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pc_valid (pc_valid),
  .acc_valid(acc_valid),
  .force_upd(force_upd),
  .reg_wr_en(reg_wr_en),
  .dbg_exc  (dbg_exc),
  .stat_q   (stat_q),
  .ctrl_q   (ctrl_q),
  .hit_vec  (hit_vec)
);

// File: tb/dbm_unit_bench.sv
module dbm_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pc_valid = 1'b0;
  logic [31:0] pc = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_len = '0;
  logic        acc_write = 1'b0;
  logic        force_upd = 1'b0;
  logic        dbg_exc;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [31:0] m_addr [4];
  logic [31:0] m_stat;
  logic [31:0] m_ctrl;

  always #2.5 clk = ~clk;

  dbm_unit u_dbm_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pc_valid(pc_valid), .pc(pc),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_len(acc_len),
    .acc_write(acc_write), .force_upd(force_upd), .dbg_exc(dbg_exc)
  );

  function automatic longint unsigned span(input logic [1:0] c);
    case (c)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 8;
      default: return 4;
    endcase
  endfunction

  function automatic logic [3:0] mhits(input logic pv, input logic [31:0] px,
      input logic av, input logic [31:0] aa, input logic [1:0] al, input logic aw);
    logic [3:0] h = '0;
    for (int n = 0; n < 4; n++) begin
      logic [1:0] k = m_ctrl[16 + 4*n +: 2];
      longint unsigned b = longint'(m_addr[n]);
      longint unsigned a = longint'(aa);
      bit ov = (a < b + span(m_ctrl[18 + 4*n +: 2])) && (b < a + span(al));
      case (k)
        2'b00: h[n] = pv && (px == m_addr[n]);
        2'b01: h[n] = av && aw && ov;
        2'b11: h[n] = av && ov;
        default: h[n] = 1'b0;
      endcase
    end
    return h;
  endfunction

  function automatic logic [31:0] mread(input logic [2:0] s);
    if (s < 3'd4) return m_addr[s[1:0]];
    if (s == 3'd4) return m_stat;
    if (s == 3'd5) return m_ctrl;
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic pv, input logic [31:0] px, input logic av,
      input logic [31:0] aa, input logic [1:0] al, input logic aw, input logic frc,
      input logic wen, input logic [2:0] sel, input logic [31:0] wd, input string req);
    logic [3:0] h;
    logic [3:0] en;
    logic       ehit;
    @(negedge clk);
    pc_valid = pv; pc = px; acc_valid = av; acc_addr = aa; acc_len = al;
    acc_write = aw; force_upd = frc; reg_wr_en = wen; reg_sel = sel; reg_wdata = wd;
    h = mhits(pv, px, av, aa, al, aw);
    for (int n = 0; n < 4; n++) en[n] = m_ctrl[2*n] | m_ctrl[2*n+1];
    ehit = |(h & en);
    if (ehit || frc) m_stat = {m_stat[31:4], h};
    else if (wen && sel == 3'd4) m_stat = wd | 32'hFFFF0FF0;
    if (wen && sel < 3'd4) m_addr[sel[1:0]] = wd;
    if (wen && sel == 3'd5) m_ctrl = wd | 32'h00000400;
    @(posedge clk);
    #1;
    pc_valid = 0; acc_valid = 0; force_upd = 0; reg_wr_en = 0;
    chk({req, " exc"}, {31'b0, dbg_exc}, {31'b0, ehit});
    reg_sel = 3'd4; #1;
    chk({req, " status"}, reg_rdata, m_stat);
    reg_sel = 3'd5; #1;
    chk({req, " control"}, reg_rdata, m_ctrl);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] wd, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 1, sel, wd, req);
  endtask

  task automatic fetch(input logic [31:0] px, input logic frc, input string req);
    step(1, px, 0, 0, 0, 0, frc, 0, 0, 0, req);
  endtask

  task automatic mem(input logic [31:0] aa, input logic [1:0] al, input logic aw, input string req);
    step(0, 0, 1, aa, al, aw, 0, 0, 0, 0, req);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4; n++) m_addr[n] = '0;
    m_stat = 32'hFFFF0FF0;
    m_ctrl = 32'h00000400;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values on every select
    for (int s = 0; s < 8; s++) begin
      reg_sel = 3'(s); #1;
      chk("R1 reset read", reg_rdata, mread(3'(s)));
    end
    chk("R1 reset exc", {31'b0, dbg_exc}, 32'h0);

    // R2: fetch breakpoint on channel 0, local enable
    wr(3'd0, 32'h0000_1000, "R12 addr write");
    wr(3'd5, 32'h0000_0001, "R7 ctrl write");
    fetch(32'h0000_1000, 0, "R2 fetch hit");
    fetch(32'h0000_1004, 0, "R9 fetch miss holds");

    // R3/R6/R7: channel 2 store watch, global enable, size 4 at 0x2002
    wr(3'd2, 32'h0000_2002, "R12 addr2 write");
    wr(3'd5, (32'h1 << 5) | (32'h1 << 24) | (32'h3 << 26), "R7 ctrl ch2");
    mem(32'h0000_2000, 2'b11, 1, "R3 store overlap");
    wr(3'd4, 32'h0, "R12 status clear");
    mem(32'h0000_2000, 2'b11, 0, "R3 read ignored");
    mem(32'h0000_2006, 2'b00, 1, "R6 upper edge miss");
    mem(32'h0000_2001, 2'b00, 1, "R6 lower edge miss");
    mem(32'h0000_2005, 2'b00, 1, "R6 last byte hit");
    mem(32'h0000_1FFC, 2'b10, 1, "R6 eight byte access");

    // R4: channel 1 any-access watch, size 8
    wr(3'd1, 32'h0000_4000, "R12 addr1 write");
    wr(3'd5, (32'h1 << 2) | (32'h3 << 20) | (32'h2 << 22), "R7 ctrl ch1");
    mem(32'h0000_4007, 2'b00, 0, "R4 read hit");
    mem(32'h0000_4008, 2'b00, 1, "R6 past end miss");
    mem(32'h0000_3FFF, 2'b01, 1, "R4 write hit");

    // R5: channel 3 port-io kind, enabled, never matches
    wr(3'd3, 32'h0000_5000, "R12 addr3 write");
    wr(3'd5, (32'h1 << 6) | (32'h2 << 28), "R5 ctrl ch3");
    mem(32'h0000_5000, 2'b11, 1, "R5 io silent");
    fetch(32'h0000_5000, 0, "R5 io fetch silent");

    // R8/R9: disabled ch0 and enabled ch1 fetch at the same pc
    wr(3'd0, 32'h0000_6000, "R12 addr0");
    wr(3'd1, 32'h0000_6000, "R12 addr1");
    wr(3'd5, 32'h0000_0008, "R7 global en ch1");
    fetch(32'h0000_6000, 0, "R8 disabled bit recorded");
    wr(3'd5, 32'h0000_0000, "R7 all disabled");
    wr(3'd4, 32'h0000_7005, "R12 status write");
    fetch(32'h0000_6000, 0, "R9 disabled only no commit");

    // R10: forced update
    fetch(32'h0000_6000, 1, "R10 force with disabled hit");
    fetch(32'h0000_9999, 1, "R10 force clears");

    // R12: write vs commit, unmapped select
    wr(3'd5, 32'h0000_0001, "R7 ch0 enable");
    step(1, 32'h0000_6000, 0, 0, 0, 0, 0, 1, 3'd4, 32'h0, "R12 commit beats write");
    wr(3'd6, 32'hDEAD_BEEF, "R12 unmapped write");
    for (int s = 0; s < 8; s++) begin
      reg_sel = 3'(s); #1;
      chk("R12 readback", reg_rdata, mread(3'(s)));
    end

    // R2/R4 same cycle: fetch on ch0 and access on ch1
    wr(3'd1, 32'h0000_7000, "R12 addr1");
    wr(3'd5, 32'h1 | (32'h1 << 2) | (32'h3 << 20), "R7 two channels");
    step(1, 32'h0000_6000, 1, 32'h0000_7000, 2'b00, 0, 0, 0, 0, 0, "R8 dual hit");
    @(negedge clk); #1;
    chk("R11 pulse ends", {31'b0, dbg_exc}, 32'h0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned r = $urandom % 16;
      logic [31:0] base = 32'h0000_3000;
      if (r == 0) wr(3'($urandom % 8), $urandom, "R12 random write");
      else if (r == 1) wr(3'(($urandom % 4)), base + ($urandom % 32), "R12 random addr");
      else if (r == 2) wr(3'd5, $urandom, "R7 random ctrl");
      else begin
        logic pv = 1'($urandom);
        logic [31:0] px = ($urandom % 4 == 0) ? m_addr[$urandom % 4] : base + ($urandom % 32);
        step(pv, px, 1'($urandom), base + ($urandom % 32), 2'($urandom), 1'($urandom),
             ($urandom % 8) == 0, ($urandom % 8) == 0, 3'd4, $urandom, "R8 random traffic");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule